// File: doc/BRIEF.md
# Reference Clock Alarm Status Registers

This block holds the alarm status for four reference clock inputs. The status sits in two 8-bit registers, each covering two inputs. Every input has two alarms.

The activity alarm is a live copy of a threshold flag. That flag comes from an external leaky-bucket accumulator. The lock alarm is sticky. It is raised when the loop cannot reach phase lock on the currently selected input within a programmable number of seconds. Software clears a lock alarm by writing 0 to its bit. Writing 1 changes nothing.

An optional mode removes a raised lock alarm by itself after a fixed count of one-second ticks. That count is 128 by default.

Whenever either alarm of an input rises, the block sends a one-cycle pulse on that input's validity-clear line. The validity register that receives this pulse lives elsewhere. The lock timeout value comes from a configuration field outside this block, and that field normally resets to 100 seconds.

Top module: `refclk_alarm_regs`

## Requirements
- R1: Each activity bit reads the input's bucket-threshold flag as sampled at the previous rising clock edge. Each activity bit reads 1 out of reset.
- R2: The register map is as follows. `reg_sel` = 0 selects inputs 0 and 1; `reg_sel` = 1 selects inputs 2 and 3. In register k:
  - bit 1 is the activity alarm of input 2k, and bit 0 is its lock alarm;
  - bit 5 is the activity alarm of input 2k+1, and bit 4 is its lock alarm;
  - bits 7, 6, 3 and 2 read 0.
- R3: Each lock bit reads 0 out of reset. The lock bit of the selected input is set on the `cfg_lock_secs`-th `sec_tick` after the timer restarts, provided `lock_ok` stays low the whole time. A timeout value of 0 behaves as 1. After it fires, the timer starts a new period.
- R4: The lock timer restarts in two cases: in any cycle where `sel_ref` differs from its value in the previous cycle, and in any cycle where `lock_ok` is high. A restart cancels a tick in that same cycle. Only the selected input's lock bit can be set.
- R5: A write with a 0 in a lock bit position clears that lock bit. A 1 in that position leaves the bit unchanged. Writes never change the activity bits.
- R6: If a hardware set and a software clear hit the same lock bit in the same cycle, the set wins.
- R7: While `auto_clr_en` is high, a raised lock bit clears on the AUTO_SECS-th `sec_tick` after it was last set or after its count last restarted. While `auto_clr_en` is low, the lock bit stays set.
- R8: `valid_clr[i]` pulses for exactly one cycle, in the same cycle that either alarm bit of input i first reads 1. Releasing reset gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bucket_hit | input | 4 | Per-input leaky-bucket threshold-reached flags |
| sel_ref | input | 2 | Index of the selected reference input |
| lock_ok | input | 1 | Loop is phase locked |
| sec_tick | input | 1 | One-cycle pulse once per second |
| cfg_lock_secs | input | 8 | Lock timeout in seconds |
| auto_clr_en | input | 1 | Enables automatic clearing of lock alarms |
| reg_sel | input | 1 | Register select for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Contents of the selected register |
| valid_clr | output | 4 | Per-input validity-clear pulses |

## Verification
The assertions check several properties on every cycle:
- the one-cycle lag of the activity bits;
- that a lock alarm only rises on the selected input and never right after a locked cycle;
- that every alarm rise produces a validity-clear pulse, and that no pulse appears without a rise;
- that the reserved bits stay zero.

The timer properties depend on long runs of ticks, so only the bench scenarios can show them. These are the exact tick count to the lock alarm, restarts on a selection change or a brief lock, the write-0/write-1 rules, set winning over clear, and the auto-clear count.

// File: rtl/refclk_alarm_pkg.sv
package refclk_alarm_pkg;
  localparam int NUM_INPUTS  = 4;
  localparam int PER_REG     = 2;
  localparam int NUM_REGS    = NUM_INPUTS / PER_REG;
  localparam int REG_W       = 8;
  localparam int SEL_W       = $clog2(NUM_INPUTS);
  localparam int RSEL_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  // bit positions inside one register, per slot
  localparam int LOCK_POS_LO = 0;
  localparam int ACT_POS_LO  = 1;
  localparam int LOCK_POS_HI = 4;
  localparam int ACT_POS_HI  = 5;

  typedef struct packed {
    logic act;
    logic lock;
  } alarm_pair_t;

  function automatic logic [REG_W-1:0] pack_reg(alarm_pair_t lo, alarm_pair_t hi);
    logic [REG_W-1:0] r;
    r = '0;
    r[LOCK_POS_LO] = lo.lock;
    r[ACT_POS_LO]  = lo.act;
    r[LOCK_POS_HI] = hi.lock;
    r[ACT_POS_HI]  = hi.act;
    return r;
  endfunction

  function automatic int lock_pos(int slot);
    return (slot == 0) ? LOCK_POS_LO : LOCK_POS_HI;
  endfunction
endpackage

// File: rtl/refclk_lock_timer.sv
module refclk_lock_timer #(
  parameter int SEL_W = 2,
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_ref,
  input  logic             lock_ok,
  input  logic             sec_tick,
  input  logic [TMO_W-1:0] tmo_secs,
  output logic             fire
);
  logic [TMO_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_prev_q;
  logic             restart;
  logic [TMO_W:0]   cnt_inc;

  assign restart = lock_ok || (sel_ref != sel_prev_q);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign fire    = sec_tick && !restart && (cnt_inc >= {1'b0, tmo_secs});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      sel_prev_q <= '0;
    end else begin
      sel_prev_q <= sel_ref;
      if (restart || fire) cnt_q <= '0;
      else if (sec_tick)   cnt_q <= cnt_inc[TMO_W-1:0];
    end
  end
endmodule

// File: rtl/refclk_alarm_cell.sv
module refclk_alarm_cell #(
  parameter int AUTO_SECS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bucket_hit,
  input  logic lock_set,
  input  logic sw_clr,
  input  logic sec_tick,
  input  logic auto_clr_en,
  output logic act_q,
  output logic lock_q,
  output logic valid_clr
);
  localparam int AUTO_W = (AUTO_SECS > 2) ? $clog2(AUTO_SECS) : 1;
  localparam logic [AUTO_W-1:0] AUTO_LAST = AUTO_W'(AUTO_SECS - 1);

  logic [AUTO_W-1:0] acnt_q;
  logic              auto_clr;
  logic              lock_d;

  assign auto_clr = lock_q && auto_clr_en && sec_tick && (acnt_q == AUTO_LAST);
  // set outranks any clear in the same cycle
  assign lock_d   = lock_set ? 1'b1 : ((sw_clr || auto_clr) ? 1'b0 : lock_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b1;
      lock_q    <= 1'b0;
      acnt_q    <= '0;
      valid_clr <= 1'b0;
    end else begin
      act_q     <= bucket_hit;
      lock_q    <= lock_d;
      valid_clr <= (bucket_hit && !act_q) || (lock_d && !lock_q);
      if (!lock_q || lock_set || sw_clr || !auto_clr_en || auto_clr) acnt_q <= '0;
      else if (sec_tick) acnt_q <= acnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/refclk_alarm_regs.sv
module refclk_alarm_regs
  import refclk_alarm_pkg::*;
#(
  parameter int TMO_W     = 8,
  parameter int AUTO_SECS = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_INPUTS-1:0] bucket_hit,
  input  logic [SEL_W-1:0]      sel_ref,
  input  logic                  lock_ok,
  input  logic                  sec_tick,
  input  logic [TMO_W-1:0]      cfg_lock_secs,
  input  logic                  auto_clr_en,
  input  logic [RSEL_W-1:0]     reg_sel,
  input  logic                  reg_wr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  output logic [NUM_INPUTS-1:0] valid_clr
);
  logic                  fire;
  logic [NUM_INPUTS-1:0] act_vec;
  logic [NUM_INPUTS-1:0] lock_vec;
  logic [REG_W-1:0]      reg_img [NUM_REGS];

  refclk_lock_timer #(.SEL_W(SEL_W), .TMO_W(TMO_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_ref  (sel_ref),
    .lock_ok  (lock_ok),
    .sec_tick (sec_tick),
    .tmo_secs (cfg_lock_secs),
    .fire     (fire)
  );

  for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_in
    localparam int REG_IDX = i / PER_REG;
    localparam int SLOT    = i % PER_REG;
    logic sel_hit;
    logic clr_req;
    assign sel_hit = fire && (sel_ref == SEL_W'(i));
    assign clr_req = reg_wr && (reg_sel == RSEL_W'(REG_IDX))
                     && !reg_wdata[lock_pos(SLOT)];
    refclk_alarm_cell #(.AUTO_SECS(AUTO_SECS)) u_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .bucket_hit  (bucket_hit[i]),
      .lock_set    (sel_hit),
      .sw_clr      (clr_req),
      .sec_tick    (sec_tick),
      .auto_clr_en (auto_clr_en),
      .act_q       (act_vec[i]),
      .lock_q      (lock_vec[i]),
      .valid_clr   (valid_clr[i])
    );
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    alarm_pair_t lo, hi;
    assign lo = '{act: act_vec[2*k],   lock: lock_vec[2*k]};
    assign hi = '{act: act_vec[2*k+1], lock: lock_vec[2*k+1]};
    assign reg_img[k] = pack_reg(lo, hi);
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (reg_sel == RSEL_W'(k)) reg_rdata = reg_img[k];
  end
endmodule

// File: rtl/refclk_alarm_regs_chk.sv
module refclk_alarm_regs_chk #(
  parameter int N     = 4,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     bucket_hit,
  input logic [SEL_W-1:0] sel_ref,
  input logic             lock_ok,
  input logic [N-1:0]     act_q,
  input logic [N-1:0]     lock_q,
  input logic [N-1:0]     valid_clr,
  input logic [7:0]       reg_rdata
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  // R1
  act_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> act_q == $past(bucket_hit));

  // R4
  lock_sel_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((lock_q & ~$past(lock_q)) & ~({{(N-1){1'b0}}, 1'b1} << $past(sel_ref))) == '0);

  // R4
  no_set_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(lock_ok) |-> (lock_q & ~$past(lock_q)) == '0);

  // R8
  pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (((act_q & ~$past(act_q)) | (lock_q & ~$past(lock_q))) & ~valid_clr) == '0);

  // R8
  pulse_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (valid_clr & ~((act_q & ~$past(act_q)) | (lock_q & ~$past(lock_q)))) == '0);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & 8'hCC) == 8'h00);
endmodule

bind refclk_alarm_regs refclk_alarm_regs_chk #(.N(NUM_INPUTS), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bucket_hit (bucket_hit),
  .sel_ref    (sel_ref),
  .lock_ok    (lock_ok),
  .act_q      (act_vec),
  .lock_q     (lock_vec),
  .valid_clr  (valid_clr),
  .reg_rdata  (reg_rdata)
);

// File: tb/refclk_alarm_regs_bench.sv
module refclk_alarm_regs_bench;
  localparam int AUTO = 5;
  localparam int TMO  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bucket_hit = 4'h0;
  logic [1:0] sel_ref = 2'd0;
  logic       lock_ok = 1'b1;
  logic       sec_tick = 1'b0;
  logic [7:0] cfg_lock_secs = 8'(TMO);
  logic       auto_clr_en = 1'b0;
  logic       reg_sel = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [3:0] valid_clr;

  logic [3:0] exp_act = 4'hF;
  logic [3:0] exp_lock = 4'h0;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  refclk_alarm_regs #(.AUTO_SECS(AUTO)) u_refclk_alarm_regs (
    .clk(clk), .rst_n(rst_n), .bucket_hit(bucket_hit), .sel_ref(sel_ref),
    .lock_ok(lock_ok), .sec_tick(sec_tick), .cfg_lock_secs(cfg_lock_secs),
    .auto_clr_en(auto_clr_en), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .valid_clr(valid_clr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_regs(string req);
    for (int k = 0; k < 2; k++) begin
      reg_sel = k[0];
      #1;
      check(req, {24'h0, reg_rdata},
            {24'h0, 2'b00, exp_act[2*k+1], exp_lock[2*k+1], 2'b00, exp_act[2*k], exp_lock[2*k]});
    end
    reg_sel = 1'b0;
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    step();
    sec_tick = 1'b0;
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic restart_timer(logic [1:0] s);
    sel_ref = s; lock_ok = 1'b1;
    step();
    lock_ok = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] prev;
    repeat (3) step();
    // R1 R2 R3 reset state
    check_regs("R1/R3 reset");
    check("R8 reset pulse", {28'h0, valid_clr}, 32'h0);
    rst_n = 1'b1;
    step();
    check("R8 no pulse after reset", {28'h0, valid_clr}, 32'h0);

    // R1 R2 R8: sweep every pair of bucket patterns
    prev = 4'hF;
    bucket_hit = 4'hF;
    step();
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        bucket_hit = a[3:0];
        step();
        exp_act = a[3:0];
        check("R8 act pulse", {28'h0, valid_clr}, {28'h0, a[3:0] & ~prev});
        prev = a[3:0];
        bucket_hit = b[3:0];
        step();
        exp_act = b[3:0];
        check("R8 act pulse", {28'h0, valid_clr}, {28'h0, b[3:0] & ~prev});
        prev = b[3:0];
        if (b[1:0] == 2'b01) check_regs("R1/R2 sweep");
      end
    end
    bucket_hit = 4'h0; step(); exp_act = 4'h0;

    // R3 R8: timeout on each selected input
    for (int s = 0; s < 4; s++) begin
      restart_timer(s[1:0]);
      tick(); tick();
      check_regs("R3 before timeout");
      tick();
      exp_lock[s] = 1'b1;
      check("R8 lock pulse", {28'h0, valid_clr}, 32'h1 << s);
      check_regs("R3 at timeout");
      lock_ok = 1'b1; step();
    end

    // R5 write rules
    wr(1'b0, 8'hFF); wr(1'b1, 8'hFF);
    check_regs("R5 write 1 ignored");
    wr(1'b0, 8'hEF); exp_lock[1] = 1'b0;
    check_regs("R5 clear slot hi only");
    bucket_hit = 4'hF; step(); exp_act = 4'hF;
    wr(1'b0, 8'h00); wr(1'b1, 8'h00); exp_lock = 4'h0;
    check_regs("R5 clear all, act untouched");
    bucket_hit = 4'h0; step(); exp_act = 4'h0;

    // R4 selection change restarts timer
    restart_timer(2'd1);
    tick(); tick();
    sel_ref = 2'd3; step();
    tick(); tick();
    check_regs("R4 sel change restart");
    tick(); exp_lock[3] = 1'b1;
    check_regs("R4 fires on new sel");
    // R4 lock_ok holds the timer
    restart_timer(2'd0); lock_ok = 1'b1;
    for (int t = 0; t < 8; t++) tick();
    check_regs("R4 locked no alarm");
    lock_ok = 1'b0; tick(); tick();
    lock_ok = 1'b1; step(); lock_ok = 1'b0;
    tick(); tick();
    check_regs("R4 brief lock restart");
    tick(); exp_lock[0] = 1'b1;
    check_regs("R4 fires after restart");
    lock_ok = 1'b1; step();

    // R6 set beats simultaneous clear
    restart_timer(2'd2);
    tick(); tick();
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h00;
    tick();
    reg_wr = 1'b0;
    exp_lock[2] = 1'b1; exp_lock[3] = 1'b0;
    check_regs("R6 set wins");
    lock_ok = 1'b1; step();

    // R7 auto clear
    wr(1'b0, 8'h00); exp_lock[1:0] = 2'b00;
    auto_clr_en = 1'b1;
    for (int t = 0; t < AUTO - 1; t++) tick();
    check_regs("R7 before auto clear");
    tick(); exp_lock[2] = 1'b0;
    check_regs("R7 auto cleared");
    auto_clr_en = 1'b0;
    restart_timer(2'd1);
    tick(); tick(); tick(); exp_lock[1] = 1'b1;
    lock_ok = 1'b1;
    for (int t = 0; t < 2 * AUTO; t++) tick();
    check_regs("R7 disabled keeps bit");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule